// File: doc/BRIEF.md
# Serial Frame Transmitter with Idle and Break Generation

This block turns words into asynchronous serial frames on a single output line. Each data frame carries a low start bit, then 7, 8 or 9 data bits sent least significant first, then one high stop bit. A two-bit length code picks the data width. When parity is on, the parity bit takes the last data position, so the frame length stays the same for a given code.

On request, the transmitter can also send an idle frame or a break frame instead of a data word. An idle frame keeps the line high for a whole frame. A break frame drives it low for a whole frame and then adds one high stop bit. Words come in through a valid/ready write port. With FIFO mode on, a queue 9 bits wide buffers several words. With it off, the same storage acts as a single holding register. Bit timing comes from an external baud-tick strobe, and each bit lasts a fixed number of ticks.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx` is high, `busy` is low and `wr_ready` is high.
- R2: A data frame is a low start bit, then the data bits with bit 0 first, then a high stop bit. The line is high whenever `busy` is low.
- R3: `len_code` 2'b10 gives 7 data bits, 2'b00 gives 8 and 2'b01 gives 9. The value 2'b11 behaves as 8. A data frame therefore spans the data width plus 2 bit times, and `busy` is high for exactly that span.
- R4: With `par_en` high and `par_odd` low, the last data position carries a bit that makes the number of ones in the data field (parity bit included) even. The data word's own top bit is dropped.
- R5: With `par_en` high and `par_odd` high, that bit makes the number of ones odd.
- R6: A one-cycle pulse on `idle_req` produces an idle frame: `busy` is high for data width plus 2 bit times and `tx` stays high throughout.
- R7: A one-cycle pulse on `brk_req` produces a break frame: `tx` is low for data width plus 2 bit times and then high for one stop bit, with `busy` high across all data width plus 3 bit times.
- R8: With `fifo_en` high, up to FIFO_DEPTH words (default 4) are accepted while no frame can start, `wr_ready` then goes low, and the words are sent in write order.
- R9: With `fifo_en` low, only one word is held: after it is accepted, `wr_ready` stays low until that word's frame starts.
- R10: Each bit lasts TICKS_PER_BIT baud ticks. `tx` changes only on clock edges where `baud_tick` is high, and a frame starts only on such an edge.
- R11: When several requests are pending, break frames go before idle frames, and idle frames go before data words.
- R12: Length and parity settings are captured when a frame starts. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Bit-timing strobe, one clock wide |
| wr_data | input | 9 | Word to send, bit 0 first |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted on a clock edge where valid and ready are both high |
| len_code | input | 2 | Data width select |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| idle_req | input | 1 | Pulse to queue an idle frame |
| brk_req | input | 1 | Pulse to queue a break frame |
| busy | output | 1 | High from the start bit through the end of the stop bit |
| tx | output | 1 | Serial line |

## Verification
A word accepted on a clock edge can start its frame no earlier than the next edge that carries a baud tick. `busy` and the start bit appear right after that edge. Each bit then holds for TICKS_PER_BIT ticks, and `busy` falls on the edge that closes the last bit. The bench samples on falling edges only. It waits for `busy` to rise, records each bit on its first cycle, and checks that the bit holds for all TICKS_PER_BIT times tick-spacing cycles. It then checks that `busy` is low one cycle after the computed frame end. Tick spacing is varied between one and three cycles, and ticks are stopped altogether to fill the queue or the holding register before any frame can start.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int TICKS_PER_BIT = 1,
  parameter int FIFO_DEPTH    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [8:0] wr_data,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       fifo_en,
  input  logic       idle_req,
  input  logic       brk_req,
  output logic       busy,
  output logic       tx
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FW = 12;

  logic [8:0]    mem [FIFO_DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          idle_pend, brk_pend, active;
  logic [FW-1:0] shreg, frame;
  logic [3:0]    bits_left, frame_bits, nd;
  logic [TW-1:0] tick_cnt;
  logic          start, pop, push, par;
  logic [8:0]    word;

  assign wr_ready = fifo_en ? (count < CW'(FIFO_DEPTH)) : (count == '0);
  assign push     = wr_valid && wr_ready;
  assign start    = !active && baud_tick && (brk_pend || idle_pend || count != '0);
  assign pop      = start && !brk_pend && !idle_pend;
  assign busy     = active;
  assign tx       = active ? shreg[0] : 1'b1;
  assign word     = mem[rd_ptr];

  always_comb begin
    case (len_code)
      2'b01:   nd = 4'd9;
      2'b10:   nd = 4'd7;
      default: nd = 4'd8;
    endcase
    par = par_odd;
    for (int i = 0; i < 8; i++)
      if (i < int'(nd) - 1) par = par ^ word[i];
    frame      = '1;
    frame_bits = nd + 4'd2;
    if (brk_pend) begin
      frame          = '0;
      frame[nd + 2]  = 1'b1;
      frame_bits     = nd + 4'd3;
    end else if (!idle_pend) begin
      frame[0] = 1'b0;
      for (int i = 0; i < 9; i++)
        if (i < int'(nd))
          frame[1 + i] = (par_en && i == int'(nd) - 1) ? par : word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(FIFO_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(FIFO_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pend  <= 1'b0;
      idle_pend <= 1'b0;
    end else begin
      if (start && brk_pend) brk_pend <= 1'b0;
      else if (start && idle_pend) idle_pend <= 1'b0;
      if (brk_req)  brk_pend  <= 1'b1;
      if (idle_req) idle_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      tick_cnt  <= '0;
    end else if (start) begin
      active    <= 1'b1;
      shreg     <= frame;
      bits_left <= frame_bits;
      tick_cnt  <= '0;
    end else if (active && baud_tick) begin
      if (tick_cnt == TW'(TICKS_PER_BIT - 1)) begin
        tick_cnt <= '0;
        if (bits_left == 4'd1) begin
          active <= 1'b0;
        end else begin
          shreg     <= {1'b1, shreg[FW-1:1]};
          bits_left <= bits_left - 4'd1;
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

module uart_frame_tx_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic [8:0] wr_data,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [1:0] len_code,
  input logic       par_en,
  input logic       par_odd,
  input logic       fifo_en,
  input logic       idle_req,
  input logic       brk_req,
  input logic       busy,
  input logic       tx
);
  AST_LINE_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx) else $error("line low while idle"); // R2
  AST_LAST_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx)) else $error("frame ended low"); // R2
  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(baud_tick)) else $error("start without tick"); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(baud_tick)) |-> $stable(tx)) else $error("tx moved without tick"); // R10
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && wr_valid && wr_ready) |=> (fifo_en || !wr_ready)) else $error("holding register overrun"); // R9
endmodule

bind uart_frame_tx uart_frame_tx_sva u_sva (.*);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int T = 2;
  localparam int D = 4;

  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic [8:0] wr_data = '0;
  logic wr_valid = 0, par_en = 0, par_odd = 0, fifo_en = 0, idle_req = 0, brk_req = 0;
  logic [1:0] len_code = 2'b00;
  logic wr_ready, busy, tx;
  int errors = 0, checks = 0, gap = 1, ph = 0;
  bit tick_on = 1;

  uart_frame_tx #(.TICKS_PER_BIT(T), .FIFO_DEPTH(D)) dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!tick_on) baud_tick = 0;
    else begin
      ph = (ph + 1 >= gap) ? 0 : ph + 1;
      baud_tick = (ph == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] lc);
    return (lc == 2'b01) ? 9 : (lc == 2'b10) ? 7 : 8;
  endfunction

  function automatic logic [12:0] data_frame(input logic [1:0] lc, input bit pe, input bit po,
                                             input logic [8:0] w);
    logic [12:0] v = '0;
    int n = width_of(lc);
    logic p = po;
    for (int i = 0; i < n; i++) v[1 + i] = w[i];
    for (int i = 0; i < n - 1; i++) p ^= w[i];
    if (pe) v[n] = p;
    v[n + 1] = 1'b1;
    return v;
  endfunction

  task automatic wr(input logic [8:0] d);
    wr_data = d;
    wr_valid = 1;
    forever begin
      if (wr_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic get_frame(input int nb, input logic [12:0] exp, input string req);
    logic [12:0] v = '0;
    int wait_c = 0, unstable = 0;
    while (!busy && wait_c < 400) begin @(negedge clk); wait_c++; end
    chk(busy, req, 0, 1);
    if (!busy) return;
    for (int b = 0; b < nb; b++)
      for (int c = 0; c < T * gap; c++) begin
        if (c == 0) v[b] = tx; else if (tx !== v[b]) unstable++;
        @(negedge clk);
      end
    chk(v == exp, req, int'(v), int'(exp));
    chk(unstable == 0, req, unstable, 0);
    chk(busy == 0, req, busy, 0);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [8:0] pats [6] = '{9'h000, 9'h1FF, 9'h155, 9'h0AA, 9'h0C3, 9'h13C};
    logic [12:0] ev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx == 1 && busy == 0 && wr_ready == 1, "R1", {tx, busy, wr_ready}, 3'b101);

    for (int lc = 0; lc < 4; lc++)
      for (int m = 0; m < 3; m++)
        for (int k = 0; k < 6; k++) begin
          len_code = 2'(lc);
          par_en = (m != 0);
          par_odd = (m == 2);
          wr(pats[k]);
          get_frame(width_of(2'(lc)) + 2, data_frame(2'(lc), par_en, par_odd, pats[k]),
                    m == 0 ? "R2/R3" : (m == 1 ? "R4" : "R5"));
        end
    par_en = 0;

    gap = 3;
    len_code = 2'b10;
    wr(9'h05A);
    get_frame(9, data_frame(2'b10, 0, 0, 9'h05A), "R10");
    gap = 1;

    for (int lc = 0; lc < 3; lc++) begin
      len_code = 2'(lc);
      pulse(idle_req);
      ev = '0;
      for (int i = 0; i < width_of(2'(lc)) + 2; i++) ev[i] = 1'b1;
      get_frame(width_of(2'(lc)) + 2, ev, "R6");
      pulse(brk_req);
      ev = '0;
      ev[width_of(2'(lc)) + 2] = 1'b1;
      get_frame(width_of(2'(lc)) + 3, ev, "R7");
    end

    len_code = 2'b00;
    fifo_en = 1;
    tick_on = 0;
    @(negedge clk);
    for (int i = 0; i < D; i++) wr(9'(8'h11 * (i + 1)));
    chk(wr_ready == 0, "R8", wr_ready, 0);
    tick_on = 1;
    for (int i = 0; i < D; i++)
      get_frame(10, data_frame(2'b00, 0, 0, 9'(8'h11 * (i + 1))), "R8");
    chk(wr_ready == 1, "R8", wr_ready, 1);

    fifo_en = 0;
    tick_on = 0;
    @(negedge clk);
    wr(9'h0F0);
    repeat (3) @(negedge clk);
    chk(wr_ready == 0, "R9", wr_ready, 0);
    tick_on = 1;
    get_frame(10, data_frame(2'b00, 0, 0, 9'h0F0), "R9");
    chk(wr_ready == 1, "R9", wr_ready, 1);

    tick_on = 0;
    @(negedge clk);
    wr(9'h033);
    pulse(idle_req);
    pulse(brk_req);
    tick_on = 1;
    ev = '0; ev[10] = 1'b1;
    get_frame(11, ev, "R11");
    ev = 13'h3FF;
    get_frame(10, ev, "R11");
    get_frame(10, data_frame(2'b00, 0, 0, 9'h033), "R11");

    wr(9'h1E7);
    fork
      get_frame(10, data_frame(2'b00, 0, 0, 9'h1E7), "R12");
      begin
        while (!busy) @(negedge clk);
        @(negedge clk);
        len_code = 2'b10; par_en = 1; par_odd = 1;
      end
    join
    len_code = 2'b00; par_en = 0; par_odd = 0;

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule